// File: doc/BRIEF.md
# Bit-Clock Burst Generator with Alignment Correction

This block paces a bit-serial datapath. Each time the instruction controller fires a trigger, the block raises a bit-clock enable for a fixed run of consecutive cycles. The enable paces shifting between the load/store shift register, the data registers and a four-stage pipelined serial ALU. Each request picks one of two run lengths. The short run moves one memory word. The long run equals the register depth plus the ALU pipeline depth. A register operation needs the long run so that every bit goes round the whole loop.

A memory transfer shifts only a word-length of bits. That would leave the register loop rotated by the difference between the two lengths. A detector inside the block marks such a request. When the short run ends, an adjusting generator adds corrective pulses at once, so the registers return to their starting alignment. The corrective pulses also raise a separate flag. Downstream logic uses this flag to steer them only to the registers and the ALU, and not to the memory path. A single-cycle done strobe follows the last pulse of every burst. Triggers that arrive while a burst is in progress are dropped.

Top module: `bitclk_burst_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, bit_en_o, adj_en_o and done_o are all 0.
- R2: A trigger accepted with mem_xfer_i=0 and long_sel_i=1 gives exactly 12 consecutive cycles with bit_en_o=1 and adj_en_o=0.
- R3: A trigger accepted with mem_xfer_i=0 and long_sel_i=0 gives exactly 8 consecutive cycles with bit_en_o=1 and adj_en_o=0.
- R4: A trigger accepted with mem_xfer_i=1 gives 8 main pulses whatever long_sel_i is. These are followed with no gap by 4 corrective pulses, so bit_en_o is 1 for 12 consecutive cycles. adj_en_o is 1 only during the last 4 of those cycles.
- R5: A trigger that arrives while bit_en_o is 1 is ignored. It neither extends the burst nor starts a new one after it.
- R6: done_o is 1 for exactly one cycle: the cycle right after the final pulse of a burst, with bit_en_o at 0 in that cycle.
- R7: A trigger is accepted in any cycle where bit_en_o is 0, including the done cycle. The first pulse appears in the next cycle.
- R8: long_sel_i and mem_xfer_i are sampled only in the cycle a trigger is accepted. Changing them during a burst has no effect on its length or on its corrective pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Burst request from the instruction controller |
| long_sel_i | input | 1 | 1 selects the long run, 0 the short run |
| mem_xfer_i | input | 1 | Request is a memory transfer (short run plus correction) |
| bit_en_o | output | 1 | Bit-clock enable, one pulse per high cycle |
| adj_en_o | output | 1 | Current pulse is an alignment-correction pulse |
| done_o | output | 1 | One-cycle strobe after the final pulse |

## Verification
Most internal faults show up as a wrong pulse count. A bad load value, a counter off by one or a lost memory-transfer mark moves the fall of bit_en_o or the done strobe, or it misplaces the rise of adj_en_o. All of these are visible within at most 13 cycles of the accepted trigger. A phase register that wrongly accepts a trigger while busy shows up one cycle after the burst ends, as an unexpected pulse following the done strobe. For this reason, every burst is followed by an idle cycle that is checked. The bench also changes the select inputs during bursts, to catch sampling outside the trigger cycle.

// File: rtl/bitclk_burst_pkg.sv
package bitclk_burst_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAIN = 2'd1,
        PH_ADJ  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   done;
    } ctl_t;

endpackage

// File: rtl/bitclk_down_counter.sv
module bitclk_down_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic         last_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (step_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == W'(1));

    // R2, R3: the phase logic never steps an exhausted count
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/bitclk_adjust_detector.sv
module bitclk_adjust_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic mem_i,
    input  logic main_last_i,
    output logic fire_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (accept_i)         pend_d = mem_i;
        else if (main_last_i) pend_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign fire_o = main_last_i && pend_q;

    // R4: correction fires at most once per marked request
    a_r4_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

endmodule

// File: rtl/bitclk_burst_gen.sv
module bitclk_burst_gen #(
    parameter int SHORT_LEN = 8,
    parameter int LONG_LEN  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic long_sel_i,
    input  logic mem_xfer_i,
    output logic bit_en_o,
    output logic adj_en_o,
    output logic done_o
);
    import bitclk_burst_pkg::*;

    localparam int ADJ_LEN = LONG_LEN - SHORT_LEN;
    localparam int CNT_W   = $clog2(LONG_LEN + 1);

    ctl_t             st_d, st_q;
    logic             accept, main_last, cnt_last, fire;
    logic             cnt_load, cnt_step;
    logic [CNT_W-1:0] cnt_val, main_len;

    assign accept    = trig_i && (st_q.phase == PH_IDLE);
    assign main_last = (st_q.phase == PH_MAIN) && cnt_last;
    assign main_len  = (mem_xfer_i || !long_sel_i) ? CNT_W'(SHORT_LEN)
                                                   : CNT_W'(LONG_LEN);

    bitclk_adjust_detector i_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .mem_i       (mem_xfer_i),
        .main_last_i (main_last),
        .fire_o      (fire)
    );

    bitclk_down_counter #(.W(CNT_W)) i_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .step_i     (cnt_step),
        .last_o     (cnt_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt_load  = accept || fire;
        cnt_val   = fire ? CNT_W'(ADJ_LEN) : main_len;
        cnt_step  = (st_q.phase != PH_IDLE);
        unique case (st_q.phase)
            PH_IDLE: begin
                if (trig_i) st_d.phase = PH_MAIN;
            end
            PH_MAIN: begin
                if (cnt_last) begin
                    if (fire) begin
                        st_d.phase = PH_ADJ;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            PH_ADJ: begin
                if (cnt_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_en_o = (st_q.phase != PH_IDLE);
    assign adj_en_o = (st_q.phase == PH_ADJ);
    assign done_o   = st_q.done;

    // R6: strobe sits right after the final pulse, with the enable low
    a_r6_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(bit_en_o) && !bit_en_o));
    // R6: strobe lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4: correction pulses are part of the burst
    a_r4_adj_inside: assert property (@(posedge clk) disable iff (!rst_n)
        adj_en_o |-> bit_en_o);
    // R4: correction joins the main run with no gap
    a_r4_adj_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adj_en_o) |-> $past(bit_en_o));
    // R7: an idle trigger starts pulsing next cycle
    a_r7_start_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bit_en_o);

endmodule

// File: tb/test_bitclk_burst_gen.sv
`timescale 1ns/1ps
module test_bitclk_burst_gen;
    localparam int SHORT = 8;
    localparam int LONG  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_i = 1'b0, long_sel_i = 1'b0, mem_xfer_i = 1'b0;
    logic bit_en_o, adj_en_o, done_o;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    bitclk_burst_gen #(.SHORT_LEN(SHORT), .LONG_LEN(LONG)) i_bitclk_burst_gen (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .long_sel_i(long_sel_i),
        .mem_xfer_i(mem_xfer_i), .bit_en_o(bit_en_o), .adj_en_o(adj_en_o),
        .done_o(done_o)
    );

    function automatic int exp_len(bit sel, bit mem);
        return (mem || sel) ? LONG : SHORT;
    endfunction

    function automatic bit exp_adj(bit mem, int idx);
        return mem && (idx > SHORT);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge; applies the trigger there and follows the burst
    task automatic run_burst(bit sel, bit mem, bit noise, bit tail_idle);
        int n = exp_len(sel, mem);
        string tag = mem ? "R4" : (sel ? "R2" : "R3");
        trig_i = 1'b1; long_sel_i = sel; mem_xfer_i = mem;
        @(negedge clk);
        for (int i = 1; i <= n; i++) begin
            chk({tag, " R7 bit_en"}, bit_en_o, 1);
            chk({tag, " adj_en"}, adj_en_o, exp_adj(mem, i));
            chk("R6 done low in burst", done_o, 0);
            if (noise) begin
                trig_i = 1'($urandom); long_sel_i = 1'($urandom);
                mem_xfer_i = 1'($urandom);
            end else begin
                trig_i = 1'b0;
            end
            @(negedge clk);
        end
        chk({tag, " R6 bit_en ends"}, bit_en_o, 0);
        chk("R6 done strobe", done_o, 1);
        chk("R6 adj low at done", adj_en_o, 0);
        trig_i = 1'b0;
        if (tail_idle) begin
            @(negedge clk);
            chk("R5 R8 no pulse after ignored trigger", bit_en_o, 0);
            chk("R6 done single", done_o, 0);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        trig_i = 1'b1; long_sel_i = 1'b1; mem_xfer_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 bit_en in reset", bit_en_o, 0);
        chk("R1 done in reset", done_o, 0);
        trig_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bit_en after reset", bit_en_o, 0);
        chk("R1 adj after reset", adj_en_o, 0);
        chk("R1 done after reset", done_o, 0);

        // Directed corner cases
        run_burst(1'b0, 1'b0, 1'b0, 1'b1);  // R3
        run_burst(1'b1, 1'b0, 1'b0, 1'b1);  // R2
        run_burst(1'b0, 1'b1, 1'b0, 1'b1);  // R4 short select
        run_burst(1'b1, 1'b1, 1'b0, 1'b1);  // R4 long select ignored
        run_burst(1'b0, 1'b0, 1'b1, 1'b1);  // R5 R8 noise during short burst
        run_burst(1'b0, 1'b1, 1'b1, 1'b1);  // R8 noise during memory burst
        run_burst(1'b1, 1'b0, 1'b0, 1'b0);  // R7 chain from done cycle
        run_burst(1'b0, 1'b1, 1'b0, 1'b0);
        run_burst(1'b0, 1'b0, 1'b0, 1'b1);

        // Random mix
        for (int k = 0; k < 200; k++) begin
            int gap = $urandom_range(0, 3);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk("R7 idle stays idle", bit_en_o, 0);
            end
            run_burst(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule